// File: doc/BRIEF.md
# Multiplexed CAM Bus Master

This block runs single byte accesses on an eight-bit bus that carries both address and data. The bus leads to a common-interface module controller. A host hands it one request at a time through a valid/ready handshake. Each request carries a direction, a 16-bit address, a write byte and a choice between two chip selects. The block then sends the address in two latched halves, low byte first. After that it either drives the write byte or releases the lines for a read. It pulls the chosen chip select low and then the read or write strobe. It holds the strobe until the target pulls its active-low acknowledge. Last, it returns every control line to idle at once and reports the sampled byte to the host.

The acknowledge input is asynchronous to the block clock and passes through a two-flop synchronizer. An access that never sees the acknowledge ends after a bounded number of cycles, and the response flags a timeout. Every phase before the wait lasts `STROBE_CYC` clocks, so slow external latches still meet their setup and hold times.

Top module: `cam_bus_master`

## Requirements
- R1: From reset the block is idle. `req_ready_o` is 1, `cs_no` is 2'b11, `rd_no` and `wr_no` are 1, `ale_lo_o`, `ale_hi_o` and `bus_oe_o` are 0, `bus_dout_o` is 0, and `rsp_valid_o`, `rsp_rdata_o` and `rsp_timeout_o` are 0.
- R2: A request is taken at a rising edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` is 1 only while the bus is idle. Request inputs that change while an access is under way have no effect on that access.
- R3: After acceptance, `bus_dout_o` carries `addr[7:0]` with `bus_oe_o` high. This lasts `STROBE_CYC` cycles with `ale_lo_o` high, then `STROBE_CYC` more cycles with `ale_lo_o` low and the byte held.
- R4: Next, `bus_dout_o` carries `addr[15:8]` with `bus_oe_o` high. This lasts `STROBE_CYC` cycles with `ale_hi_o` high, then `STROBE_CYC` cycles with it low.
- R5: From the data phase to the end of the access, a write drives the write byte with `bus_oe_o` high. A read holds `bus_oe_o` low and `bus_dout_o` at 0. The data phase itself lasts `STROBE_CYC` cycles, with all selects and strobes idle.
- R6: Then `cs_no[sel]` alone goes low, where sel 0 picks bit 0. It stays low for `STROBE_CYC` cycles before `rd_no` (read) or `wr_no` (write) goes low. Only one chip select and only one of the two strobes is ever low at a time, and a strobe is low only while a chip select is low.
- R7: `ack_ni` goes through two synchronizing flops. When `ack_ni` is first sampled low at rising edge E during the strobe phase, the access ends at edge E+2. If the synchronized acknowledge is already low when the strobe phase starts, the access ends one cycle after the strobe falls.
- R8: If the synchronized acknowledge stays high for `TIMEOUT_CYC` strobe cycles, the access ends anyway and `rsp_timeout_o` is 1. A normal end sets it to 0.
- R9: When an access ends, `rsp_valid_o` is high for exactly one cycle, and in that same cycle `req_ready_o` is 1. `rsp_rdata_o` is `bus_din_i` as sampled in the last strobe cycle, even after a timeout. It holds until the next response.
- R10: At the end of an access, the chip select and the read/write strobe return high at the same clock edge.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Engine idle, request can be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Target address |
| req_wdata_i | input | 8 | Byte to write |
| req_cs_sel_i | input | 1 | Chip select choice (0 = cs_no[0]) |
| rsp_valid_o | output | 1 | One-cycle end-of-access pulse |
| rsp_rdata_o | output | 8 | Byte sampled at end of access |
| rsp_timeout_o | output | 1 | Last access ended by timeout |
| bus_dout_o | output | 8 | Bus lines, driven value |
| bus_oe_o | output | 1 | Bus output enable |
| bus_din_i | input | 8 | Bus lines, sampled value |
| ale_lo_o | output | 1 | Low address latch strobe |
| ale_hi_o | output | 1 | High address latch strobe |
| cs_no | output | 2 | Chip selects, active low |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| ack_ni | input | 1 | Target acknowledge, active low, asynchronous |

## Verification
The assertions check the bus rules that must hold on every cycle. They cover mutual exclusion of chip selects, of the two strobes and of the two latch strobes; a strobe only under a chip select; the output enable off during a read strobe; selects and strobes rising at one edge; a quiet bus whenever ready is high; and a one-cycle response pulse. The order and length of the phases, the latched address bytes, the synchronizer delay, the timeout length and the captured byte depend on the request and on when the acknowledge arrives. Only the bench's cycle-by-cycle reference model shows these. It runs scenarios with a late acknowledge, an early acknowledge, no acknowledge, and request inputs changed while busy.

// File: rtl/cam_bus_pkg.sv
package cam_bus_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NUM_CS = 2;
  localparam int unsigned SEL_W  = $clog2(NUM_CS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALO,
    ST_ALO_REL,
    ST_AHI,
    ST_AHI_REL,
    ST_DATA,
    ST_SEL,
    ST_WAIT
  } cam_state_e;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [SEL_W-1:0]  sel;
  } cam_req_t;
endpackage

// File: rtl/cam_ack_sync.sv
module cam_ack_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b1;
        else         chain_q[g] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b1;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cam_phase_timer.sv
module cam_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cam_bus_seq.sv
module cam_bus_seq
  import cam_bus_pkg::*;
#(
  parameter int unsigned STROBE_CYC  = 2,
  parameter int unsigned TIMEOUT_CYC = 100000,
  parameter int unsigned CNT_W       = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  cam_req_t          req_i,
  input  logic              ack_low_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              clr_o,
  output cam_state_e        state_o,
  output cam_req_t          req_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_timeout_o
);
  localparam logic [CNT_W-1:0] PHASE_LAST = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(TIMEOUT_CYC - 1);

  cam_state_e        state_q, state_d;
  cam_req_t          req_q;
  logic              end_ok, end_to, accept;
  logic              rsp_valid_q, rsp_to_q;
  logic [DATA_W-1:0] rsp_data_q;

  assign accept = (state_q == ST_IDLE) && req_valid_i;
  assign end_ok = (state_q == ST_WAIT) && ack_low_i;
  assign end_to = (state_q == ST_WAIT) && !ack_low_i && (cnt_i == WAIT_LAST);

  always_comb begin
    state_d = state_q;
    clr_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        clr_o = 1'b1;
        if (req_valid_i) state_d = ST_ALO;
      end
      ST_ALO, ST_ALO_REL, ST_AHI, ST_AHI_REL, ST_DATA, ST_SEL: begin
        if (cnt_i == PHASE_LAST) begin
          clr_o   = 1'b1;
          state_d = cam_state_e'(state_q + 3'd1);
        end
      end
      ST_WAIT: begin
        if (end_ok || end_to) begin
          clr_o   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      req_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) req_q <= req_i;
    end
  end

  // response: last sampled byte is returned on both normal end and timeout
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_to_q    <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= end_ok || end_to;
      if (end_ok || end_to) begin
        rsp_to_q   <= end_to;
        rsp_data_q <= din_i;
      end
    end
  end

  assign state_o       = state_q;
  assign req_o         = req_q;
  assign rsp_valid_o   = rsp_valid_q;
  assign rsp_rdata_o   = rsp_data_q;
  assign rsp_timeout_o = rsp_to_q;
endmodule

// File: rtl/cam_bus_drive.sv
module cam_bus_drive
  import cam_bus_pkg::*;
(
  input  cam_state_e        state_i,
  input  cam_req_t          req_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              oe_o,
  output logic              ale_lo_o,
  output logic              ale_hi_o,
  output logic [NUM_CS-1:0] cs_no,
  output logic              rd_no,
  output logic              wr_no
);
  logic sel_active, strobe_active, data_phase;

  assign sel_active    = (state_i == ST_SEL) || (state_i == ST_WAIT);
  assign strobe_active = (state_i == ST_WAIT);
  assign data_phase    = (state_i == ST_DATA) || sel_active;

  always_comb begin
    dout_o = '0;
    oe_o   = 1'b0;
    unique case (state_i)
      ST_ALO, ST_ALO_REL: begin
        dout_o = req_i.addr[DATA_W-1:0];
        oe_o   = 1'b1;
      end
      ST_AHI, ST_AHI_REL: begin
        dout_o = req_i.addr[ADDR_W-1:DATA_W];
        oe_o   = 1'b1;
      end
      default: begin
        if (data_phase && req_i.wr) begin
          dout_o = req_i.wdata;
          oe_o   = 1'b1;
        end
      end
    endcase
  end

  assign ale_lo_o = (state_i == ST_ALO);
  assign ale_hi_o = (state_i == ST_AHI);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_no[g] = !(sel_active && (req_i.sel == SEL_W'(g)));
  end

  assign rd_no = !(strobe_active && !req_i.wr);
  assign wr_no = !(strobe_active && req_i.wr);
endmodule

// File: rtl/cam_bus_master.sv
module cam_bus_master
  import cam_bus_pkg::*;
#(
  parameter int unsigned STROBE_CYC  = 2,
  parameter int unsigned TIMEOUT_CYC = 100000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_write_i,
  input  logic [15:0] req_addr_i,
  input  logic [7:0]  req_wdata_i,
  input  logic        req_cs_sel_i,
  output logic        rsp_valid_o,
  output logic [7:0]  rsp_rdata_o,
  output logic        rsp_timeout_o,
  output logic [7:0]  bus_dout_o,
  output logic        bus_oe_o,
  input  logic [7:0]  bus_din_i,
  output logic        ale_lo_o,
  output logic        ale_hi_o,
  output logic [1:0]  cs_no,
  output logic        rd_no,
  output logic        wr_no,
  input  logic        ack_ni
);
  localparam int unsigned CNT_MAX = (TIMEOUT_CYC > STROBE_CYC) ? TIMEOUT_CYC : STROBE_CYC;
  localparam int unsigned CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;

  cam_state_e       state;
  cam_req_t         req_in, req_cur;
  logic             ack_sync, clr;
  logic [CNT_W-1:0] cnt;

  assign req_in.wr    = req_write_i;
  assign req_in.addr  = req_addr_i;
  assign req_in.wdata = req_wdata_i;
  assign req_in.sel   = req_cs_sel_i;

  cam_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ack_ni),
    .sync_o  (ack_sync)
  );

  cam_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .cnt_o  (cnt)
  );

  cam_bus_seq #(
    .STROBE_CYC  (STROBE_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .CNT_W       (CNT_W)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_i         (req_in),
    .ack_low_i     (!ack_sync),
    .din_i         (bus_din_i),
    .cnt_i         (cnt),
    .clr_o         (clr),
    .state_o       (state),
    .req_o         (req_cur),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_rdata_o   (rsp_rdata_o),
    .rsp_timeout_o (rsp_timeout_o)
  );

  cam_bus_drive u_drive (
    .state_i  (state),
    .req_i    (req_cur),
    .dout_o   (bus_dout_o),
    .oe_o     (bus_oe_o),
    .ale_lo_o (ale_lo_o),
    .ale_hi_o (ale_hi_o),
    .cs_no    (cs_no),
    .rd_no    (rd_no),
    .wr_no    (wr_no)
  );

  assign req_ready_o = (state == ST_IDLE);
endmodule

// File: rtl/cam_bus_master_chk.sv
module cam_bus_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_ready_o,
  input logic       rsp_valid_o,
  input logic       bus_oe_o,
  input logic       ale_lo_o,
  input logic       ale_hi_o,
  input logic [1:0] cs_no,
  input logic       rd_no,
  input logic       wr_no
);
  assert_one_cs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_no) <= 1);

  assert_rdwr_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));

  assert_strobe_under_cs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !wr_no) |-> (cs_no != 2'b11));

  assert_ale_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ale_lo_o && ale_hi_o) && !((ale_lo_o || ale_hi_o) && (cs_no != 2'b11)));

  assert_read_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !bus_oe_o);

  assert_strobe_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rd_no) || $rose(wr_no)) |-> (cs_no == 2'b11));

  assert_cs_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cs_no[0]) || $rose(cs_no[1])) |-> (rd_no && wr_no && $past(!rd_no || !wr_no)));

  assert_ready_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (cs_no == 2'b11 && rd_no && wr_no && !ale_lo_o && !ale_hi_o));

  assert_rsp_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_rsp_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> req_ready_o);
endmodule

bind cam_bus_master cam_bus_master_chk u_chk (.*);

// File: tb/cam_bus_master_test.sv
module cam_bus_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int S  = 3;
  localparam int TO = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, req_sel = 1'b0, ack_n = 1'b1;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, bus_din = '0;
  logic        req_ready, rsp_valid, rsp_to, bus_oe, ale_lo, ale_hi, rd_n, wr_n;
  logic [7:0]  rsp_rdata, bus_dout;
  logic [1:0]  cs_n;

  cam_bus_master #(.STROBE_CYC(S), .TIMEOUT_CYC(TO)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_cs_sel_i(req_sel),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_timeout_o(rsp_to),
    .bus_dout_o(bus_dout), .bus_oe_o(bus_oe), .bus_din_i(bus_din),
    .ale_lo_o(ale_lo), .ale_hi_o(ale_hi), .cs_no(cs_n), .rd_no(rd_n), .wr_no(wr_n),
    .ack_ni(ack_n)
  );

  int checks = 0, fails = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1..6 timed phases, 7 strobe wait
  int m_phase = 0, m_cnt = 0;
  bit m_s1 = 1, m_s2 = 1, m_wr = 0, m_sel = 0, m_rv = 0, m_to = 0;
  logic [15:0] m_addr = '0;
  logic [7:0]  m_wdata = '0, m_rdata = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_s1 = 1; m_s2 = 1; m_rv = 0; m_to = 0; m_rdata = '0;
      m_wr = 0; m_sel = 0; m_addr = '0; m_wdata = '0;
    end else begin
      m_rv = 0;
      if (m_phase == 0) begin
        if (req_valid) begin
          m_phase = 1; m_cnt = 0;
          m_wr = req_write; m_addr = req_addr; m_wdata = req_wdata; m_sel = req_sel;
        end
      end else if (m_phase < 7) begin
        if (m_cnt == S-1) begin m_phase++; m_cnt = 0; end
        else m_cnt++;
      end else begin
        if (!m_s2 || m_cnt == TO-1) begin
          m_rv = 1; m_to = m_s2; m_rdata = bus_din; m_phase = 0; m_cnt = 0;
        end else m_cnt++;
      end
      m_s2 = m_s1;
      m_s1 = ack_n;
    end
  end

  // per-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] e_dout;
      bit e_oe;
      e_oe   = (m_phase >= 1 && m_phase <= 4) || (m_phase >= 5 && m_wr);
      e_dout = !e_oe ? 8'h00 : (m_phase <= 2) ? m_addr[7:0] :
               (m_phase <= 4) ? m_addr[15:8] : m_wdata;
      check("R2 ready", req_ready, m_phase == 0);
      check("R3 ale_lo", ale_lo, m_phase == 1);
      check("R4 ale_hi", ale_hi, m_phase == 3);
      check("R5 bus_oe", bus_oe, e_oe);
      check("R5 bus_dout", bus_dout, e_dout);
      check("R6 cs_no", cs_n, (m_phase >= 6) ? (m_sel ? 2'b01 : 2'b10) : 2'b11);
      check("R6 rd_no", rd_n, !(m_phase == 7 && !m_wr));
      check("R10 wr_no", wr_n, !(m_phase == 7 && m_wr));
      check("R9 rsp_valid", rsp_valid, m_rv);
      check("R9 rsp_rdata", rsp_rdata, m_rdata);
      check("R8 rsp_timeout", rsp_to, m_to);
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  // ack_dly < 0 means never acknowledge
  task automatic access(input bit wr, input logic [15:0] a, input logic [7:0] d,
                        input bit sel, input int ack_dly, input bit early,
                        input logic [7:0] din, input bit hold_busy, output int lat);
    step();
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_sel = sel;
    step();
    if (hold_busy) begin
      req_write = ~wr; req_addr = ~a; req_wdata = ~d; req_sel = ~sel;
    end else req_valid = 0;
    if (early) begin ack_n = 0; bus_din = din; end
    while (rd_n && wr_n) step();
    lat = 0;
    if (!early) begin
      bus_din = din;
      if (ack_dly >= 0) begin
        repeat (ack_dly) step();
        ack_n = 0;
      end
    end
    while (!rsp_valid) begin step(); lat++; end
    req_valid = 0; ack_n = 1;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", wd);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat;
    #3;
    // R1 reset state
    check("R1 ready", req_ready, 1);
    check("R1 cs_no", cs_n, 2'b11);
    check("R1 rd/wr", {rd_n, wr_n}, 2'b11);
    check("R1 strobes/oe", {ale_lo, ale_hi, bus_oe}, 3'b000);
    check("R1 rsp", {rsp_valid, rsp_to, rsp_rdata}, 10'h0);
    repeat (3) step();
    rst_n = 1;
    repeat (2) step();

    // R3 R4 R5 R6 write on cs0, ack after delay: R7 ends two edges after ack sampled
    access(1, 16'hA55A, 8'h3C, 0, 2, 0, 8'h11, 0, lat);
    check("R7 ack latency", lat, 3);
    check("R8 no timeout", rsp_to, 0);
    // read on cs1
    access(0, 16'h1234, 8'h00, 1, 5, 0, 8'hC7, 0, lat);
    check("R9 read byte", rsp_rdata, 8'hC7);
    check("R7 ack latency read", lat, 3);
    // R8 timeout, byte still the last sampled
    access(0, 16'h00FF, 8'h00, 0, -1, 0, 8'h5E, 0, lat);
    check("R8 timeout flag", rsp_to, 1);
    check("R8 timeout length", lat, TO);
    check("R9 byte after timeout", rsp_rdata, 8'h5E);
    // R7 early ack: ends one cycle after strobe
    access(1, 16'hFF00, 8'hE1, 1, 0, 1, 8'h99, 0, lat);
    check("R7 early ack", lat, 1);
    check("R8 timeout cleared", rsp_to, 0);
    // R2 request inputs changed while busy have no effect
    access(1, 16'h0F0F, 8'h81, 0, 1, 0, 8'h42, 1, lat);
    repeat (4) step();
    check("R2 stays idle", req_ready, 1);
    // ack at last possible cycle before timeout: ack wins
    access(0, 16'h8001, 8'h00, 1, TO - 3, 0, 8'h77, 0, lat);
    check("R8 ack on last cycle", rsp_to, 0);
    check("R9 last-cycle byte", rsp_rdata, 8'h77);
    // back-to-back
    access(0, 16'h2468, 8'h00, 0, 0, 0, 8'h24, 0, lat);
    access(1, 16'h1357, 8'h13, 1, 3, 0, 8'h00, 0, lat);
    repeat (5) step();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule